// File: doc/BRIEF.md
# Spare-Bit Stack Ready Handshake

This block moves the Sa6 spare national bits of an E1 link between the line side and a host, one CRC-4 double multiframe (32 frames) at a time. On the receive side it gathers the Sa6 bit of each odd-numbered frame into a 16-bit stack. When frame 0 comes round, it moves the finished stack into a holding register the host can read, and it raises a receive ready flag. On the transmit side, frame 0 moves the host-written holding register into the outgoing stack, and the bits of that stack go out in the odd frames that follow. At the same moment a transmit ready flag is raised, telling the host it may load the contents for the next double multiframe.

The framer supplies a frame-start strobe together with a 5-bit frame number, in which 0 marks the start of the double multiframe. It also supplies a loss-of-frame-alignment indication. Each flag drops on the first host access to its own stack, and each flag is re-evaluated at frame 0. The host has one double multiframe (4 ms) to service a flag. While alignment is lost, the receive side keeps its flag and holding register as they were.

Top module: `sa_stack_hs`

## Requirements
- R1: After reset, both ready flags are 0, both holding registers read back as 0, and the transmit Sa6 output is 1.
- R2: The Sa6 bit sampled with the strobe of odd frame 2k+1 becomes bit 15-k of the receive holding register at the next frame-0 strobe. Frames 1 to 31 fill all 16 bits.
- R3: A frame-0 strobe with alignment present sets the receive ready flag, visible in the cycle after the strobe.
- R4: A host read or write with stack select 0 (receive) clears the receive ready flag, and it leaves the receive holding register unchanged.
- R5: A frame-0 strobe while loss of alignment is high changes neither the receive ready flag nor the receive holding register.
- R6: A host write with stack select 1 (transmit) loads the transmit holding register. The data bus shows the transmit holding register when select is 1 and the receive holding register when select is 0.
- R7: At each frame-0 strobe, the transmit holding register is copied into the outgoing stack. With the strobe of odd frame 2k+1, the transmit output takes bit 15-k of that stack. With the strobe of an even frame it takes 1. The output is registered and changes in the cycle after the strobe.
- R8: If the host writes nothing between two frame-0 strobes, the same 16 bits are sent again in the next double multiframe.
- R9: Every frame-0 strobe sets the transmit ready flag, whatever the alignment state. A host read or write with select 1 clears it.
- R10: If a frame-0 strobe and a host access to a stack fall in the same cycle, the flag is set. A transmit write in that cycle reaches the holding register only, so the outgoing stack takes the previous holding value.
- R11: An access to one stack does not change the other stack's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_tick_i | input | 1 | One-cycle strobe at the start of each frame |
| frm_cnt_i | input | 5 | Frame number within the double multiframe, valid with the strobe |
| lfa_i | input | 1 | Loss of frame alignment |
| rx_sa_i | input | 1 | Received Sa6 bit, sampled with the strobe |
| tx_sa_o | output | 1 | Sa6 bit to transmit in the current frame |
| hst_sel_i | input | 1 | Stack select: 0 receive, 1 transmit |
| hst_rd_i | input | 1 | Host read strobe |
| hst_wr_i | input | 1 | Host write strobe |
| hst_wdata_i | input | 16 | Host write data |
| hst_rdata_o | output | 16 | Holding register of the selected stack |
| rx_rdy_o | output | 1 | Receive stack ready flag |
| tx_rdy_o | output | 1 | Transmit stack ready flag |

## Verification
The checker watches every cycle for four things: how the flags are set and cleared around frame-0 strobes and host accesses, the receive freeze during loss of alignment, the write path into the transmit holding register, and the forced 1 in even frames. Only the bench's scenarios can show the bit ordering of a whole double multiframe in both directions, the repeat of old transmit data when the host stays silent, and the one-interval delay of a write that coincides with frame 0.

// File: rtl/sa_hs_pkg.sv
`timescale 1ns/1ps
package sa_hs_pkg;
  localparam int unsigned DEF_FRM_W = 5;
  typedef enum logic {STK_RX = 1'b0, STK_TX = 1'b1} stk_sel_e;
endpackage

// File: rtl/sa_rdy_flag.sv
`timescale 1ns/1ps
module sa_rdy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic frz_i,
  input  logic acc_i,
  output logic rdy_o
);
  // frame 0 replaces any pending flag; access clears it otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdy_o <= 1'b0;
    else if (sof_i && !frz_i) rdy_o <= 1'b1;
    else if (acc_i)           rdy_o <= 1'b0;
  end
endmodule

// File: rtl/sa_rx_stack.sv
`timescale 1ns/1ps
module sa_rx_stack #(
  parameter int unsigned FRM_W = 5,
  localparam int unsigned IDX_W = FRM_W - 1,
  localparam int unsigned SA_W  = 1 << IDX_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [FRM_W-1:0] cnt_i,
  input  logic            sa_i,
  input  logic            commit_i,
  output logic [SA_W-1:0] hold_o
);
  logic [SA_W-1:0] stk;

  // frame 2k+1 lands in bit SA_W-1-k
  for (genvar k = 0; k < SA_W; k++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stk[k] <= 1'b0;
      else if (tick_i && cnt_i[0] && (cnt_i[FRM_W-1:1] == IDX_W'(SA_W - 1 - k)))
        stk[k] <= sa_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_o <= '0;
    else if (commit_i) hold_o <= stk;
  end
endmodule

// File: rtl/sa_tx_stack.sv
`timescale 1ns/1ps
module sa_tx_stack #(
  parameter int unsigned FRM_W = 5,
  localparam int unsigned IDX_W = FRM_W - 1,
  localparam int unsigned SA_W  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [FRM_W-1:0] cnt_i,
  input  logic             sof_i,
  input  logic             wr_i,
  input  logic [SA_W-1:0]  wdata_i,
  output logic [SA_W-1:0]  hold_o,
  output logic             sa_o
);
  logic [SA_W-1:0]  shf;
  logic [IDX_W-1:0] bit_idx;

  assign bit_idx = ~cnt_i[FRM_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_o <= '0;
    else if (wr_i) hold_o <= wdata_i;
  end

  // shift copy takes the pre-write holding value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shf <= '0;
    else if (sof_i) shf <= hold_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sa_o <= 1'b1;
    else if (tick_i) sa_o <= cnt_i[0] ? shf[bit_idx] : 1'b1;
  end
endmodule

// File: rtl/sa_stack_hs.sv
`timescale 1ns/1ps
module sa_stack_hs
  import sa_hs_pkg::*;
#(
  parameter int unsigned FRM_W = DEF_FRM_W,
  localparam int unsigned SA_W = 1 << (FRM_W - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_tick_i,
  input  logic [FRM_W-1:0] frm_cnt_i,
  input  logic             lfa_i,
  input  logic             rx_sa_i,
  output logic             tx_sa_o,
  input  logic             hst_sel_i,
  input  logic             hst_rd_i,
  input  logic             hst_wr_i,
  input  logic [SA_W-1:0]  hst_wdata_i,
  output logic [SA_W-1:0]  hst_rdata_o,
  output logic             rx_rdy_o,
  output logic             tx_rdy_o
);
  logic            sof, acc, rx_acc, tx_acc, tx_wr, rx_commit;
  logic [SA_W-1:0] rx_hold, tx_hold;

  assign sof       = frm_tick_i && (frm_cnt_i == '0);
  assign acc       = hst_rd_i || hst_wr_i;
  assign rx_acc    = acc && (stk_sel_e'(hst_sel_i) == STK_RX);
  assign tx_acc    = acc && (stk_sel_e'(hst_sel_i) == STK_TX);
  assign tx_wr     = hst_wr_i && (stk_sel_e'(hst_sel_i) == STK_TX);
  assign rx_commit = sof && !lfa_i;

  sa_rx_stack #(.FRM_W(FRM_W)) u_rx_stk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (frm_tick_i),
    .cnt_i    (frm_cnt_i),
    .sa_i     (rx_sa_i),
    .commit_i (rx_commit),
    .hold_o   (rx_hold)
  );

  sa_tx_stack #(.FRM_W(FRM_W)) u_tx_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (frm_tick_i),
    .cnt_i   (frm_cnt_i),
    .sof_i   (sof),
    .wr_i    (tx_wr),
    .wdata_i (hst_wdata_i),
    .hold_o  (tx_hold),
    .sa_o    (tx_sa_o)
  );

  sa_rdy_flag u_rx_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof),
    .frz_i  (lfa_i),
    .acc_i  (rx_acc),
    .rdy_o  (rx_rdy_o)
  );

  sa_rdy_flag u_tx_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof),
    .frz_i  (1'b0),
    .acc_i  (tx_acc),
    .rdy_o  (tx_rdy_o)
  );

  assign hst_rdata_o = (stk_sel_e'(hst_sel_i) == STK_TX) ? tx_hold : rx_hold;
endmodule

// File: rtl/sa_stack_hs_chk.sv
`timescale 1ns/1ps
module sa_stack_hs_chk #(
  parameter int unsigned FRM_W = 5,
  localparam int unsigned SA_W = 1 << (FRM_W - 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frm_tick_i,
  input logic [FRM_W-1:0] frm_cnt_i,
  input logic             lfa_i,
  input logic             hst_sel_i,
  input logic             hst_rd_i,
  input logic             hst_wr_i,
  input logic [SA_W-1:0]  hst_wdata_i,
  input logic             rx_rdy_o,
  input logic             tx_rdy_o,
  input logic             tx_sa_o,
  input logic [SA_W-1:0]  rx_hold,
  input logic [SA_W-1:0]  tx_hold
);
  logic f0, racc, tacc;
  assign f0   = frm_tick_i && (frm_cnt_i == '0);
  assign racc = (hst_rd_i || hst_wr_i) && !hst_sel_i;
  assign tacc = (hst_rd_i || hst_wr_i) && hst_sel_i;

  a_r3_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f0 && !lfa_i |=> rx_rdy_o);
  a_r4_rx_access_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    racc && !f0 |=> !rx_rdy_o && $stable(rx_hold));
  a_r5_lfa_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f0 && lfa_i && !racc |=> $stable(rx_rdy_o) && $stable(rx_hold));
  a_r6_tx_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_wr_i && hst_sel_i |=> tx_hold == $past(hst_wdata_i));
  a_r7_even_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_tick_i && !frm_cnt_i[0] |=> tx_sa_o);
  a_r9_tx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f0 |=> tx_rdy_o);
  a_r9_tx_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tacc && !f0 |=> !tx_rdy_o);
  a_r11_tx_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    racc && !f0 |=> $stable(tx_rdy_o));
  a_r11_rx_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tacc && !f0 |=> $stable(rx_rdy_o));
endmodule

bind sa_stack_hs sa_stack_hs_chk #(.FRM_W(FRM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_tick_i  (frm_tick_i),
  .frm_cnt_i   (frm_cnt_i),
  .lfa_i       (lfa_i),
  .hst_sel_i   (hst_sel_i),
  .hst_rd_i    (hst_rd_i),
  .hst_wr_i    (hst_wr_i),
  .hst_wdata_i (hst_wdata_i),
  .rx_rdy_o    (rx_rdy_o),
  .tx_rdy_o    (tx_rdy_o),
  .tx_sa_o     (tx_sa_o),
  .rx_hold     (rx_hold),
  .tx_hold     (tx_hold)
);

// File: tb/sa_stack_hs_tb_top.sv
`timescale 1ns/1ps
module sa_stack_hs_tb_top;
  localparam int unsigned NV = 4;
  // {rx word, tx word}
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_3C5A, 32'h8001_7FFE, 32'hFFFF_0000, 32'h1234_EDCB
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  cnt = '0;
  logic        lfa = 1'b0;
  logic        rx_sa = 1'b1;
  logic        tx_sa;
  logic        sel = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_rdy, tx_rdy;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;

  sa_stack_hs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frm_tick_i(tick), .frm_cnt_i(cnt),
    .lfa_i(lfa), .rx_sa_i(rx_sa), .tx_sa_o(tx_sa), .hst_sel_i(sel),
    .hst_rd_i(rd), .hst_wr_i(wr), .hst_wdata_i(wdata), .hst_rdata_o(rdata),
    .rx_rdy_o(rx_rdy), .tx_rdy_o(tx_rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick_frame(input logic [4:0] f, input logic b);
    @(negedge clk); tick = 1'b1; cnt = f; rx_sa = b;
    @(negedge clk); tick = 1'b0; rx_sa = 1'b1;
  endtask

  task automatic host(input logic s, input logic r, input logic w, input logic [15:0] d);
    @(negedge clk); sel = s; rd = r; wr = w; wdata = d;
    @(negedge clk); rd = 1'b0; wr = 1'b0;
  endtask

  task automatic peek(input logic s, output logic [15:0] d);
    @(negedge clk); sel = s; #1; d = rdata;
  endtask

  // frames 1..31: feed rx word, collect tx word
  task automatic run_body(input logic [15:0] rxw, output logic [15:0] txw, output logic even_ok);
    even_ok = 1'b1; txw = '0;
    for (int f = 1; f < 32; f++) begin
      tick_frame(5'(f), f[0] ? rxw[15 - (f >> 1)] : 1'b1);
      if (f[0]) txw[15 - (f >> 1)] = tx_sa;
      else if (tx_sa !== 1'b1) even_ok = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] d, txw, w1, w2;
    logic        ev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rx_rdy", 32'(rx_rdy), 0);
    check("R1 tx_rdy", 32'(tx_rdy), 0);
    check("R1 tx_sa", 32'(tx_sa), 1);
    peek(1'b0, d); check("R1 rx hold", 32'(d), 0);
    peek(1'b1, d); check("R1 tx hold", 32'(d), 0);
    rst_n = 1'b1;

    host(1'b1, 1'b0, 1'b1, VEC[0][15:0]);
    peek(1'b1, d); check("R6 tx hold write", 32'(d), 32'(VEC[0][15:0]));
    tick_frame(5'd0, 1'b1);
    check("R9 tx set", 32'(tx_rdy), 1);

    for (int i = 0; i < NV; i++) begin
      run_body(VEC[i][31:16], txw, ev);
      check("R7 tx bits", 32'(txw), 32'(VEC[i][15:0]));
      check("R7 even frames", 32'(ev), 1);
      if (i < NV - 1) begin
        host(1'b1, 1'b0, 1'b1, VEC[i+1][15:0]);
        check("R9 tx clr by write", 32'(tx_rdy), 0);
      end
      tick_frame(5'd0, 1'b1);
      check("R3 rx set", 32'(rx_rdy), 1);
      check("R9 tx set", 32'(tx_rdy), 1);
      peek(1'b0, d); check("R2 rx hold", 32'(d), 32'(VEC[i][31:16]));
      host(1'b0, 1'b1, 1'b0, 16'h0);
      check("R4 rx clr by read", 32'(rx_rdy), 0);
      check("R11 tx kept", 32'(tx_rdy), 1);
    end

    // R8 no new write: repeat
    run_body(16'h0F0F, txw, ev);
    check("R8 repeat", 32'(txw), 32'(VEC[NV-1][15:0]));
    host(1'b1, 1'b1, 1'b0, 16'h0);
    check("R9 tx clr by read", 32'(tx_rdy), 0);
    check("R11 rx kept", 32'(rx_rdy), 0);

    // R5 freeze with flag low
    lfa = 1'b1; tick_frame(5'd0, 1'b1); lfa = 1'b0;
    check("R5 rx flag frozen low", 32'(rx_rdy), 0);
    check("R9 tx set under lfa", 32'(tx_rdy), 1);
    peek(1'b0, d); check("R5 rx hold frozen", 32'(d), 32'(VEC[NV-1][31:16]));

    // R5 freeze with flag high
    run_body(16'h6B29, txw, ev);
    tick_frame(5'd0, 1'b1);
    check("R3 rx set", 32'(rx_rdy), 1);
    run_body(16'h9D40, txw, ev);
    lfa = 1'b1; tick_frame(5'd0, 1'b1); lfa = 1'b0;
    check("R5 rx flag frozen high", 32'(rx_rdy), 1);
    peek(1'b0, d); check("R5 rx hold kept", 32'(d), 32'h6B29);

    // R4 write to rx stack ignored
    host(1'b0, 1'b0, 1'b1, 16'hFFFF);
    check("R4 rx clr by write", 32'(rx_rdy), 0);
    peek(1'b0, d); check("R4 rx hold unchanged", 32'(d), 32'h6B29);

    // R10 frame 0 and tx write in same cycle
    w1 = 16'hC0DE; w2 = 16'h1357;
    host(1'b1, 1'b0, 1'b1, w1);
    run_body(16'h0, txw, ev);
    @(negedge clk); tick = 1'b1; cnt = 5'd0; sel = 1'b1; wr = 1'b1; wdata = w2;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    check("R10 tx flag set wins", 32'(tx_rdy), 1);
    peek(1'b1, d); check("R10 hold takes write", 32'(d), 32'(w2));
    run_body(16'h0, txw, ev);
    check("R10 shift takes old hold", 32'(txw), 32'(w1));
    tick_frame(5'd0, 1'b1);
    run_body(16'h0, txw, ev);
    check("R10 write sent next", 32'(txw), 32'(w2));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule